// File: doc/BRIEF.md
# Partitioned Multichannel Buffer Controller

This block divides one shared on-chip word store into separate circular queues, one per channel. A host gives each channel a region by writing a first and a last word address and a fill threshold. Before storing an allocation, the block checks it against a set of placement rules. It returns a one-cycle completion pulse carrying a result code. A channel runs only while its activate level is high and it holds an accepted allocation. Deactivating a channel discards what it holds and returns its pointers to the beginning of its region.

Data enters through a valid/ready write stream tagged with a channel number and leaves through a valid/ready read stream that names the channel to drain. A producer that sees `wr_ready` low must hold its word stable until it is taken. A consumer reads a word on any cycle where `rd_valid` and `rd_ready` are both high. For each channel, the block raises a level transfer request when enough data is buffered, or earlier when a message end marker is waiting in the queue.

Top module: `shfifo_part`

## Requirements
- R1: After reset, no channel holds an allocation, `chan_active`, `xfer_req` and `cfg_done` are all zero, and `wr_ready` and `rd_valid` are low.
- R2: One cycle after `cfg_valid`, `cfg_done` pulses high with `cfg_code`. An allocation aimed at an active channel returns code 1, and the channel's stored region is left unchanged.
- R3: An allocation whose first address is odd or whose last address is even returns code 2.
- R4: An allocation whose last address is not strictly above its first address returns code 3.
- R5: An allocation with last minus first below 3 (a region of fewer than four words) returns code 4.
- R6: An allocation covering the whole store (first 0, last all ones) returns code 5.
- R7: An allocation that intersects the region of any other allocated channel returns code 6. A channel's own old region never counts as a conflict. Code 0 means the allocation was accepted and stored. When several rules are broken, the lowest nonzero code is the one reported.
- R8: `chan_active[i]` equals activate level `act_req[i]` ANDed with "channel i is allocated". An unallocated channel never accepts a write.
- R9: `wr_ready` is high only for an active channel that is not full, and `rd_valid` only for an active channel that is not empty. Words come out in write order, together with their end marker, and wrap from the last address back to the first.
- R10: A channel holds exactly last − first + 1 words, then refuses writes. Deactivating a channel empties it.
- R11: `xfer_req[i]` is high while channel i is active and holds at least one word and at least its threshold.
- R12: While any word written with the end marker is still buffered in a channel, that channel's `xfer_req` is high whatever its fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_valid | input | 1 | Allocation request strobe |
| cfg_ch | input | CW | Channel being allocated |
| cfg_start | input | AW | First word address of the region |
| cfg_end | input | AW | Last word address of the region |
| cfg_thresh | input | AW+1 | Fill threshold for the transfer request |
| cfg_done | output | 1 | Allocation result pulse |
| cfg_code | output | 3 | Result code, 0 = accepted |
| act_req | input | NCH | Per-channel activate level |
| chan_active | output | NCH | Per-channel running status |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word taken this cycle |
| wr_ch | input | CW | Write channel |
| wr_data | input | DW | Write word |
| wr_eom | input | 1 | Word ends a message |
| rd_ready | input | 1 | Consumer takes the word |
| rd_valid | output | 1 | Read word available |
| rd_ch | input | CW | Channel to drain |
| rd_data | output | DW | Read word |
| rd_eom | output | 1 | Read word ends a message |
| xfer_req | output | NCH | Per-channel transfer request |

## Verification
On every cycle, the assertions check that accepted regions keep their parity and stay pairwise disjoint. They also check that no write lands in a full queue and no read drains an empty one, that queue offsets stay inside the region, that a pending end marker always has data behind it, and that writes only reach allocated channels. Only the bench scenarios can show the rest. That covers the choice of result code when a rule is broken, that a refused allocation leaves the old region size in force, that data comes back in order across a wrap, the exact capacity of a region, that deactivation discards data, and the exact fill level at which the transfer request turns on.

// File: rtl/shfifo_pkg.sv
package shfifo_pkg;
  typedef enum logic [2:0] {
    REJ_NONE    = 3'd0,
    REJ_ACTIVE  = 3'd1,
    REJ_PARITY  = 3'd2,
    REJ_ORDER   = 3'd3,
    REJ_SMALL   = 3'd4,
    REJ_WHOLE   = 3'd5,
    REJ_OVERLAP = 3'd6
  } rej_e;
endpackage

// File: rtl/shfifo_alloc.sv
module shfifo_alloc
  import shfifo_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_valid,
  input  logic [CW-1:0]            cfg_ch,
  input  logic [AW-1:0]            cfg_start,
  input  logic [AW-1:0]            cfg_end,
  input  logic [AW:0]              cfg_thresh,
  input  logic [NCH-1:0]           act_req,
  output logic [NCH-1:0]           alloc_vld,
  output logic [NCH-1:0][AW-1:0]   base,
  output logic [NCH-1:0][AW-1:0]   last,
  output logic [NCH-1:0][AW:0]     thr,
  output logic                     cfg_done,
  output logic [2:0]               cfg_code
);
  rej_e verdict;
  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int j = 0; j < NCH; j++) begin
      if (alloc_vld[j] && (CW'(j) != cfg_ch) &&
          !((cfg_end < base[j]) || (cfg_start > last[j])))
        hit = 1'b1;
    end
    if (act_req[cfg_ch] && alloc_vld[cfg_ch])       verdict = REJ_ACTIVE;
    else if (cfg_start[0] || !cfg_end[0])           verdict = REJ_PARITY;
    else if (cfg_end <= cfg_start)                  verdict = REJ_ORDER;
    else if ((cfg_end - cfg_start) < AW'(3))        verdict = REJ_SMALL;
    else if ((cfg_start == '0) && (&cfg_end))       verdict = REJ_WHOLE;
    else if (hit)                                   verdict = REJ_OVERLAP;
    else                                            verdict = REJ_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_vld <= '0;
      base      <= '0;
      last      <= '0;
      thr       <= '0;
      cfg_done  <= 1'b0;
      cfg_code  <= 3'd0;
    end else begin
      cfg_done <= cfg_valid;
      if (cfg_valid) cfg_code <= verdict;
      if (cfg_valid && verdict == REJ_NONE) begin
        alloc_vld[cfg_ch] <= 1'b1;
        base[cfg_ch]      <= cfg_start;
        last[cfg_ch]      <= cfg_end;
        thr[cfg_ch]       <= cfg_thresh;
      end
    end
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_chk
      p_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_vld[i] |-> (!base[i][0] && last[i][0] && last[i] > base[i]));
      for (genvar k = i + 1; k < NCH; k++) begin : g_pair
        p_disjoint_r7: assert property (@(posedge clk) disable iff (!rst_n)
          (alloc_vld[i] && alloc_vld[k]) |-> (last[i] < base[k] || last[k] < base[i]));
      end
    end
  endgenerate

  p_frozen_when_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && act_req[cfg_ch] && alloc_vld[cfg_ch]) |=> $stable(base) && $stable(last));
endmodule

// File: rtl/shfifo_chan.sv
module shfifo_chan #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] last,
  input  logic [AW:0]   thr,
  input  logic          wr_fire,
  input  logic          wr_eom,
  input  logic          rd_fire,
  input  logic          rd_eom,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          full,
  output logic          empty,
  output logic          req
);
  logic [AW-1:0] wofs, rofs, span;
  logic          wwrap, rwrap;
  logic [AW:0]   size, fill, eomc;

  assign span  = last - base;
  assign size  = {1'b0, span} + (AW+1)'(1);
  assign waddr = base + wofs;
  assign raddr = base + rofs;
  assign empty = (wofs == rofs) && (wwrap == rwrap);
  assign full  = (wofs == rofs) && (wwrap != rwrap);
  assign fill  = (wwrap == rwrap) ? ({1'b0, wofs} - {1'b0, rofs})
                                  : (size - ({1'b0, rofs} - {1'b0, wofs}));
  assign req   = active && (((fill != '0) && (fill >= thr)) || (eomc != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wofs <= '0; rofs <= '0; wwrap <= 1'b0; rwrap <= 1'b0; eomc <= '0;
    end else if (!active) begin
      wofs <= '0; rofs <= '0; wwrap <= 1'b0; rwrap <= 1'b0; eomc <= '0;
    end else begin
      if (wr_fire) begin
        if (wofs == span) begin
          wofs  <= '0;
          wwrap <= ~wwrap;
        end else begin
          wofs <= wofs + AW'(1);
        end
      end
      if (rd_fire) begin
        if (rofs == span) begin
          rofs  <= '0;
          rwrap <= ~rwrap;
        end else begin
          rofs <= rofs + AW'(1);
        end
      end
      eomc <= eomc + (AW+1)'(wr_fire && wr_eom) - (AW+1)'(rd_fire && rd_eom);
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_fire);
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_fire);
  p_ofs_in_region_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (wofs <= span && rofs <= span));
  p_eom_has_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (eomc != '0) |-> !empty);
endmodule

// File: rtl/shfifo_ram.sv
module shfifo_ram #(
  parameter int AW = 8,
  parameter int WW = 9,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/shfifo_part.sv
module shfifo_part #(
  parameter int NCH = 8,
  parameter int AW  = 8,
  parameter int DW  = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_valid,
  input  logic [CW-1:0]  cfg_ch,
  input  logic [AW-1:0]  cfg_start,
  input  logic [AW-1:0]  cfg_end,
  input  logic [AW:0]    cfg_thresh,
  output logic           cfg_done,
  output logic [2:0]     cfg_code,
  input  logic [NCH-1:0] act_req,
  output logic [NCH-1:0] chan_active,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [CW-1:0]  wr_ch,
  input  logic [DW-1:0]  wr_data,
  input  logic           wr_eom,
  input  logic           rd_ready,
  output logic           rd_valid,
  input  logic [CW-1:0]  rd_ch,
  output logic [DW-1:0]  rd_data,
  output logic           rd_eom,
  output logic [NCH-1:0] xfer_req
);
  logic [NCH-1:0]          alloc_vld, full, empty;
  logic [NCH-1:0][AW-1:0]  base, last, waddr_v, raddr_v;
  logic [NCH-1:0][AW:0]    thr;
  logic                    wr_fire, rd_fire;

  shfifo_alloc #(.NCH(NCH), .AW(AW)) u_alloc (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ch(cfg_ch),
    .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_thresh(cfg_thresh),
    .act_req(act_req), .alloc_vld(alloc_vld), .base(base), .last(last),
    .thr(thr), .cfg_done(cfg_done), .cfg_code(cfg_code)
  );

  assign chan_active = act_req & alloc_vld;
  assign wr_ready    = chan_active[wr_ch] && !full[wr_ch];
  assign wr_fire     = wr_valid && wr_ready;
  assign rd_valid    = chan_active[rd_ch] && !empty[rd_ch];
  assign rd_fire     = rd_valid && rd_ready;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      shfifo_chan #(.AW(AW)) u_chan (
        .clk(clk), .rst_n(rst_n), .active(chan_active[i]),
        .base(base[i]), .last(last[i]), .thr(thr[i]),
        .wr_fire(wr_fire && (wr_ch == CW'(i))), .wr_eom(wr_eom),
        .rd_fire(rd_fire && (rd_ch == CW'(i))), .rd_eom(rd_eom),
        .waddr(waddr_v[i]), .raddr(raddr_v[i]),
        .full(full[i]), .empty(empty[i]), .req(xfer_req[i])
      );
    end
  endgenerate

  shfifo_ram #(.AW(AW), .WW(DW + 1)) u_ram (
    .clk(clk), .we(wr_fire), .waddr(waddr_v[wr_ch]), .wdata({wr_eom, wr_data}),
    .raddr(raddr_v[rd_ch]), .rdata({rd_eom, rd_data})
  );

  p_write_needs_alloc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> alloc_vld[wr_ch]);
  p_req_only_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req & ~chan_active) == '0);
endmodule

// File: tb/shfifo_part_bench.sv
module shfifo_part_bench;
  localparam int NCH = 8, AW = 8, DW = 8, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid = 0; logic [CW-1:0] cfg_ch = 0;
  logic [AW-1:0] cfg_start = 0, cfg_end = 0; logic [AW:0] cfg_thresh = 0;
  logic cfg_done; logic [2:0] cfg_code;
  logic [NCH-1:0] act_req = 0, chan_active, xfer_req;
  logic wr_valid = 0, wr_ready, wr_eom = 0; logic [CW-1:0] wr_ch = 0; logic [DW-1:0] wr_data = 0;
  logic rd_ready = 0, rd_valid, rd_eom; logic [CW-1:0] rd_ch = 0; logic [DW-1:0] rd_data;

  int checks = 0, errors = 0;
  logic [DW:0] sb[$];

  always #4 clk = ~clk;

  shfifo_part #(.NCH(NCH), .AW(AW), .DW(DW)) u_shfifo_part (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ch(cfg_ch),
    .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_thresh(cfg_thresh),
    .cfg_done(cfg_done), .cfg_code(cfg_code), .act_req(act_req),
    .chan_active(chan_active), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_ch(wr_ch), .wr_data(wr_data), .wr_eom(wr_eom), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_ch(rd_ch), .rd_data(rd_data), .rd_eom(rd_eom),
    .xfer_req(xfer_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares every word the design hands out against the scoreboard
  always @(negedge clk) begin
    #3;
    if (rd_valid && rd_ready) begin
      if (sb.size() == 0) chk("R9 unexpected word", int'({rd_eom, rd_data}), -1);
      else chk("R9 read order", int'({rd_eom, rd_data}), int'(sb.pop_front()));
    end
  end

  task automatic cfg(input int ch, input int s, input int e, input int th, input int code, input string tag);
    @(negedge clk);
    cfg_valid = 1; cfg_ch = CW'(ch); cfg_start = AW'(s); cfg_end = AW'(e); cfg_thresh = (AW+1)'(th);
    @(posedge clk); #1 cfg_valid = 0;
    chk({tag, " done"}, int'(cfg_done), 1);
    chk({tag, " code"}, int'(cfg_code), code);
  endtask

  task automatic wr(input int ch, input int d, input bit eom, input bit exp_rdy, input string tag);
    @(negedge clk);
    wr_valid = 1; wr_ch = CW'(ch); wr_data = DW'(d); wr_eom = eom;
    #2 chk(tag, int'(wr_ready), int'(exp_rdy));
    if (wr_ready) sb.push_back({eom, DW'(d)});
    @(posedge clk); #1 wr_valid = 0;
  endtask

  task automatic rd(input int ch, input bit exp_vld, input string tag);
    @(negedge clk);
    rd_ch = CW'(ch); rd_ready = 1;
    #2 chk(tag, int'(rd_valid), int'(exp_vld));
    @(posedge clk); #1 rd_ready = 0;
  endtask

  task automatic act(input int ch, input bit v);
    @(negedge clk); act_req[ch] = v; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 cfg_done", int'(cfg_done), 0);
    chk("R1 chan_active", int'(chan_active), 0);
    chk("R1 xfer_req", int'(xfer_req), 0);
    chk("R1 wr_ready", int'(wr_ready), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    @(negedge clk) rst_n = 1;

    cfg(0, 0, 255, 4, 5, "R6 whole store");
    cfg(0, 1, 9, 4, 2, "R3 odd start");
    cfg(0, 2, 8, 4, 2, "R3 even end");
    cfg(0, 10, 3, 4, 3, "R4 end below start");
    cfg(0, 4, 5, 4, 4, "R5 two words");
    cfg(0, 0, 7, 4, 0, "R7 accept ch0");
    cfg(1, 6, 13, 2, 6, "R7 overlap ch0");
    cfg(1, 8, 15, 2, 0, "R7 accept ch1");
    cfg(0, 0, 7, 4, 0, "R7 own region");

    // R8: unallocated channel stays idle
    act(2, 1);
    chk("R8 unallocated active", int'(chan_active[2]), 0);
    wr(2, 8'h11, 0, 0, "R8 write to unallocated");
    act(2, 0);

    act(0, 1);
    chk("R8 ch0 active", int'(chan_active[0]), 1);
    cfg(0, 16, 31, 4, 1, "R2 active refused");

    for (int i = 0; i < 3; i++) wr(0, 8'h10 + i, 0, 1, "R9 write");
    chk("R11 below threshold", int'(xfer_req[0]), 0);
    wr(0, 8'h13, 0, 1, "R9 write");
    chk("R11 at threshold", int'(xfer_req[0]), 1);
    for (int i = 0; i < 4; i++) rd(0, 1, "R9 read valid");
    chk("R11 drained", int'(xfer_req[0]), 0);

    // fill across the wrap point, capacity 8 proves region kept (R2, R10)
    for (int i = 0; i < 8; i++) wr(0, 8'h20 + i, 0, 1, "R10 fill");
    wr(0, 8'h99, 0, 0, "R10 full refuses");
    for (int i = 0; i < 8; i++) rd(0, 1, "R9 read wrap");
    rd(0, 0, "R9 empty");

    wr(0, 8'h55, 1, 1, "R12 eom write");
    chk("R12 eom forces req", int'(xfer_req[0]), 1);
    rd(0, 1, "R12 eom read");
    chk("R12 req clears", int'(xfer_req[0]), 0);

    wr(0, 8'h61, 0, 1, "R10 pre-deact");
    wr(0, 8'h62, 0, 1, "R10 pre-deact");
    act(0, 0);
    sb.delete();
    act(0, 1);
    rd(0, 0, "R10 discarded on deactivate");
    act(0, 0);

    act(1, 1);
    wr(1, 8'h71, 0, 1, "R9 ch1 write");
    chk("R11 ch1 below", int'(xfer_req[1]), 0);
    wr(1, 8'h72, 1, 1, "R9 ch1 write");
    chk("R11 ch1 at threshold", int'(xfer_req[1]), 1);
    rd(1, 1, "R9 ch1 read");
    rd(1, 1, "R9 ch1 read");
    chk("R12 ch1 cleared", int'(xfer_req[1]), 0);

    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule